// File: doc/BRIEF.md
# Floating-Point Control/Status Register with Exception Check

This block keeps the 32-bit control/status word of a floating-point unit. From that word it derives two things. The first is an exception request. The second is the eight condition codes, which compare and branch logic read and write one at a time.

Software or the pipeline can replace the whole word through a write port. A condition-code port reads or sets a single code by index. The word is always available on a read-back output. The exception request is purely combinational from the stored word. Cause bits are not computed here; they arrive through the full-word write.

The condition codes are not packed contiguously. Code 0 sits apart from codes 1 to 7, and bit 24 between them is an ordinary register bit. The exception check also treats one cause bit specially: the unimplemented-operation cause has no matching enable.

Top module: `fcsr_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first write, the register reads as 32'h0000_0000 and exc_req_o is 0.
- R2: A full-word write (wr_en_i high) without a condition-code write makes csr_o equal wr_data_i after the next rising clock edge. With neither write enabled, the register holds its value.
- R3: A condition-code write (cc_wr_en_i high) sets the selected bit to cc_wr_val_i and leaves every other bit unchanged. Index 0 maps to bit 23, and index n (1..7) maps to bit 24+n. Bit 24 is never touched by this port.
- R4: cc_rd_o shows, in the same cycle, bit 23 of the register when cc_rd_sel_i is 0, and bit 24+n when cc_rd_sel_i is n, for n from 1 to 7.
- R5: When both writes happen in the same cycle, the selected condition-code bit takes cc_wr_val_i. All other bits take wr_data_i.
- R6: exc_req_o is 1 whenever bit 17 (unimplemented-operation cause) of the register is 1, whatever the enable bits hold.
- R7: exc_req_o is 1 whenever bit 12+k and bit 7+k are both 1 for some k in 0..4 (cause bits 16..12 against enable bits 11..7).
- R8: exc_req_o is 0 when bit 17 is 0 and no cause/enable pair of R7 is set. This holds even if causes and enables are set in different positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Full-word write enable |
| wr_data_i | input | 32 | Full-word write data |
| cc_wr_en_i | input | 1 | Condition-code write enable |
| cc_wr_sel_i | input | 3 | Index of the condition code to write |
| cc_wr_val_i | input | 1 | Value for the selected condition code |
| cc_rd_sel_i | input | 3 | Index of the condition code to read |
| cc_rd_o | output | 1 | Selected condition code |
| csr_o | output | 32 | Current register contents |
| exc_req_o | output | 1 | Exception request |

## Verification
The register is the only state in the block. Both write ports therefore show their effect on csr_o exactly one rising edge later. cc_rd_o and exc_req_o are combinational from that register, so they follow in the same cycle that csr_o changes, or immediately when cc_rd_sel_i changes. The bench drives inputs at the falling edge, waits for the next rising edge plus a small delay, and compares all outputs against its model. For read selections it changes cc_rd_sel_i between edges and samples after a short settle.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int CSR_W     = 32;
  localparam int IDX_W     = $clog2(CSR_W);
  localparam int CC_NUM    = 8;
  localparam int CC_SEL_W  = $clog2(CC_NUM);
  localparam int CC0_BIT   = 23;
  localparam int CCN_BASE  = 24;
  localparam int UNIMP_BIT = 17;
  localparam int CAUSE_LO  = 12;
  localparam int ENABLE_LO = 7;
  localparam int FLAG_N    = 5;

  // code 0 lives apart from codes 1..7
  function automatic logic [IDX_W-1:0] cc_pos(input logic [CC_SEL_W-1:0] sel);
    if (sel == '0) return IDX_W'(CC0_BIT);
    return IDX_W'(CCN_BASE) + IDX_W'(sel);
  endfunction
endpackage

// File: rtl/fcsr_reg.sv
module fcsr_reg
  import fcsr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CSR_W-1:0]    wr_data_i,
  input  logic                cc_wr_en_i,
  input  logic [CC_SEL_W-1:0] cc_wr_sel_i,
  input  logic                cc_wr_val_i,
  output logic [CSR_W-1:0]    q_o
);
  logic [CSR_W-1:0] q_q, q_d;

  always_comb begin
    q_d = wr_en_i ? wr_data_i : q_q;
    if (cc_wr_en_i) q_d[cc_pos(cc_wr_sel_i)] = cc_wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fcsr_cc_mux.sv
module fcsr_cc_mux
  import fcsr_pkg::*;
(
  input  logic [CSR_W-1:0]    csr_i,
  input  logic [CC_SEL_W-1:0] sel_i,
  output logic                cc_o
);
  logic [CC_NUM-1:0] cc_vec;

  for (genvar i = 0; i < CC_NUM; i++) begin : g_cc
    assign cc_vec[i] = csr_i[cc_pos(CC_SEL_W'(i))];
  end

  assign cc_o = cc_vec[sel_i];
endmodule

// File: rtl/fcsr_exc.sv
module fcsr_exc
  import fcsr_pkg::*;
(
  input  logic [CSR_W-1:0] csr_i,
  output logic             exc_o
);
  logic [FLAG_N-1:0] hit;

  for (genvar k = 0; k < FLAG_N; k++) begin : g_hit
    assign hit[k] = csr_i[CAUSE_LO+k] & csr_i[ENABLE_LO+k];
  end

  // unimplemented-operation cause has no enable
  assign exc_o = csr_i[UNIMP_BIT] | (|hit);
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        cc_wr_en_i,
  input  logic [2:0]  cc_wr_sel_i,
  input  logic        cc_wr_val_i,
  input  logic [2:0]  cc_rd_sel_i,
  output logic        cc_rd_o,
  output logic [31:0] csr_o,
  output logic        exc_req_o
);
  logic [CSR_W-1:0] csr_q;

  fcsr_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cc_wr_en_i  (cc_wr_en_i),
    .cc_wr_sel_i (cc_wr_sel_i),
    .cc_wr_val_i (cc_wr_val_i),
    .q_o         (csr_q)
  );

  fcsr_cc_mux u_cc (
    .csr_i (csr_q),
    .sel_i (cc_rd_sel_i),
    .cc_o  (cc_rd_o)
  );

  fcsr_exc u_exc (
    .csr_i (csr_q),
    .exc_o (exc_req_o)
  );

  assign csr_o = csr_q;
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
  import fcsr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        cc_wr_en_i,
  input logic [2:0]  cc_wr_sel_i,
  input logic        cc_wr_val_i,
  input logic [2:0]  cc_rd_sel_i,
  input logic        cc_rd_o,
  input logic [31:0] csr_o,
  input logic        exc_req_o
);
  logic [CSR_W-1:0] sel_mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_mask_q <= '0;
    else         sel_mask_q <= CSR_W'(1) << cc_pos(cc_wr_sel_i);
  end

  assert_reset_zero_R1: assert property (@(posedge clk_i) !rst_ni |-> csr_o == '0);

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !cc_wr_en_i |=> csr_o == $past(wr_data_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !cc_wr_en_i |=> $stable(csr_o));

  assert_cc_only_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_wr_en_i && !wr_en_i |=> ((csr_o ^ $past(csr_o)) & ~sel_mask_q) == '0);

  assert_cc_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_wr_en_i |=> (|(csr_o & sel_mask_q)) == $past(cc_wr_val_i));

  assert_cc_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_rd_o == csr_o[cc_pos(cc_rd_sel_i)]);

  assert_both_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_wr_en_i && wr_en_i |=> ((csr_o ^ $past(wr_data_i)) & ~sel_mask_q) == '0);

  assert_unimp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[17] |-> exc_req_o);

  assert_enabled_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(csr_o[16:12] & csr_o[11:7])) |-> exc_req_o);

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_o[17] && !(|(csr_o[16:12] & csr_o[11:7])) |-> !exc_req_o);
endmodule

bind fcsr_unit fcsr_unit_chk chk_i (.*);

// File: tb/fcsr_unit_tb_top.sv
module fcsr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cc_wr_en = 1'b0;
  logic [2:0]  cc_wr_sel = '0;
  logic        cc_wr_val = 1'b0;
  logic [2:0]  cc_rd_sel = '0;
  logic        cc_rd;
  logic [31:0] csr;
  logic        exc_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  fcsr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cc_wr_en_i(cc_wr_en), .cc_wr_sel_i(cc_wr_sel), .cc_wr_val_i(cc_wr_val),
    .cc_rd_sel_i(cc_rd_sel), .cc_rd_o(cc_rd), .csr_o(csr), .exc_req_o(exc_req)
  );

  function automatic int cc_idx(input logic [2:0] s);
    return (s == 3'd0) ? 23 : 24 + int'(s);
  endfunction

  function automatic logic exp_exc(input logic [31:0] v);
    return v[17] | (|(v[16:12] & v[11:7]));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // one write cycle, then compare all outputs against the model
  task automatic apply(input logic we, input logic [31:0] wd, input logic cwe,
                       input logic [2:0] cs, input logic cv, input string req);
    @(negedge clk);
    wr_en = we; wr_data = wd; cc_wr_en = cwe; cc_wr_sel = cs; cc_wr_val = cv;
    if (we) model = wd;
    if (cwe) model[cc_idx(cs)] = cv;
    @(posedge clk);
    #1;
    wr_en = 1'b0; cc_wr_en = 1'b0;
    chk(req, csr, model);
    chk({req, "/R6-R8 exc"}, 32'(exc_req), 32'(exp_exc(model)));
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 8; s++) begin
      cc_rd_sel = 3'(s);
      #0.5;
      chk(req, 32'(cc_rd), 32'(model[cc_idx(3'(s))]));
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #5;
    chk("R1 reset csr", csr, 32'h0);
    chk("R1 reset exc", 32'(exc_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", csr, 32'h0);
    read_all("R4 reset read");

    apply(1'b1, 32'hA5A5_0000, 1'b0, 3'd0, 1'b0, "R2 full write");
    apply(1'b0, 32'hFFFF_FFFF, 1'b0, 3'd0, 1'b0, "R2 hold");
    apply(1'b1, 32'h0002_0000, 1'b0, 3'd0, 1'b0, "R6 unimp alone");
    chk("R6 unimp exc", 32'(exc_req), 32'h1);
    apply(1'b1, 32'h0000_1100, 1'b0, 3'd0, 1'b0, "R8 mismatched pair");
    chk("R8 no exc", 32'(exc_req), 32'h0);
    apply(1'b1, 32'h0000_2100, 1'b0, 3'd0, 1'b0, "R7 matched pair");
    chk("R7 exc", 32'(exc_req), 32'h1);
    apply(1'b1, 32'h0001_0800, 1'b0, 3'd0, 1'b0, "R7 top pair");
    chk("R7 top exc", 32'(exc_req), 32'h1);

    apply(1'b1, 32'h0000_0000, 1'b0, 3'd0, 1'b0, "R2 clear");
    for (int s = 0; s < 8; s++) begin
      apply(1'b0, 32'h0, 1'b1, 3'(s), 1'b1, "R3 cc set");
      chk("R3 cc bit pos", csr, (32'h1 << cc_idx(3'(s))) | model & ~(32'h1 << cc_idx(3'(s))));
    end
    chk("R3 bit 24 untouched", 32'(csr[24]), 32'h0);
    read_all("R4 all set");
    apply(1'b1, 32'h0100_0000, 1'b0, 3'd0, 1'b0, "R2 bit24 only");
    read_all("R4 bit24 invisible");
    apply(1'b1, 32'hFFFF_FFFF, 1'b1, 3'd3, 1'b0, "R5 both writes");
    chk("R5 cc bit", 32'(csr[27]), 32'h0);
    apply(1'b1, 32'h0000_0000, 1'b1, 3'd0, 1'b1, "R5 both writes cc0");
    chk("R5 cc0 bit", csr, 32'h0080_0000);

    for (int i = 0; i < 400; i++) begin
      logic we, cwe;
      logic [31:0] wd;
      we = 1'($urandom_range(0, 2) == 0);
      cwe = 1'($urandom_range(0, 1));
      wd = $urandom();
      if ($urandom_range(0, 3) == 0) wd[17] = 1'b0;
      if ($urandom_range(0, 3) == 0) wd[11:7] = '0;
      apply(we, wd, cwe, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R2/R3/R5 random");
      cc_rd_sel = 3'($urandom_range(0, 7));
      #0.5;
      chk("R4 random read", 32'(cc_rd), 32'(model[cc_idx(cc_rd_sel)]));
    end

    @(negedge clk); rst_n = 1'b0; model = '0;
    #1;
    chk("R1 async reset", csr, 32'h0);
    finish_run();
  end
endmodule